// File: doc/BRIEF.md
# Indirect Jump Landing Pad Guard

This block sits beside the retire stage of an in-order core and enforces forward-edge control-flow integrity. For every retiring instruction it sees the program counter, the 32-bit encoding, an indirect-jump flag, the number of the register that supplied the jump target, and the current contents of x7.

When tracking is on, an indirect jump through any register other than the return registers (x1, x5) or the software-guarded register (x7) arms an expectation. The next instruction to retire must then be a landing pad. A landing pad is an AUIPC whose destination is x0. It must sit at a word-aligned PC. If its 20-bit label is nonzero, that label must equal the upper 20 bits of x7. Any breach raises a software-check exception that carries a fixed cause and trap value.

A small register port holds the enable and lock bits for the running task. Once the lock is set, the enable bit can no longer change, and only reset clears the lock.

Top module: `lpad_guard`

## Requirements
- R1: While enabled, a retiring indirect jump (`ret_is_ijmp`=1) whose `ret_src_reg` is not 1, 5 or 7 arms the expectation, so the next retiring instruction is checked. A jump that is itself reported as a violation does not arm.
- R2: Indirect jumps through x1, x5 or x7 never arm the expectation.
- R3: While disabled, no jump arms the expectation and no exception is raised for the following instruction.
- R4: A checked instruction is a valid pad only when `ret_insn[6:0]`=7'b0010111 and `ret_insn[11:7]`=0. Any other encoding raises an exception.
- R5: A checked instruction with `ret_pc[1:0]` nonzero raises an exception, even when its encoding is a valid pad.
- R6: The pad label is `ret_insn[31:12]`. A label of zero is accepted whatever x7 holds. A nonzero label must equal `ret_x7[31:12]`, and the low x7 bits are ignored.
- R7: An exception is signalled combinationally in the same cycle as the offending `ret_valid`, for that cycle only, with `xcpt_cause`=18 and `xcpt_tval`=2.
- R8: The expectation survives cycles without a retire. It is consumed by the next retire and cleared by `trap_taken`. A retire in the same cycle as `trap_taken` is not checked and arms nothing.
- R9: A pad retiring while nothing is expected is a hint with no effect: no exception, whatever its label or alignment.
- R10: A write (`cfg_we`) loads `cfg_wdata_en` into the enable bit, and the new value shows on `cfg_enable` from the next cycle.
- R11: A write with `cfg_wdata_lock`=1 sets the lock. While locked, enable writes are ignored. The lock clears only on reset.
- R12: After reset the enable and lock bits are 0, nothing is expected, and no exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | XLEN | PC of the retiring instruction |
| ret_insn | input | 32 | Encoding of the retiring instruction |
| ret_is_ijmp | input | 1 | Retiring instruction is an indirect jump |
| ret_src_reg | input | 5 | Register number supplying the jump target |
| ret_x7 | input | XLEN | Current value of x7 |
| trap_taken | input | 1 | A trap is taken this cycle |
| cfg_we | input | 1 | Write strobe for the control bits |
| cfg_wdata_en | input | 1 | Enable value to write |
| cfg_wdata_lock | input | 1 | Set the lock when 1 |
| cfg_enable | output | 1 | Current enable bit |
| cfg_locked | output | 1 | Current lock bit |
| xcpt_valid | output | 1 | Software-check exception pulse |
| xcpt_cause | output | XLEN | Exception cause (18 when valid, else 0) |
| xcpt_tval | output | XLEN | Trap value (2 when valid, else 0) |

## Verification
On every cycle the assertions check several relations. The expectation rises only after a tracked jump, and any retire that arms nothing leaves it clear. A trap leaves it clear. An exception never occurs without an armed expectation and a retire. The enable bit holds while locked, and the lock never falls.

Other behaviour can only be shown by the bench's scenarios. These are the exact classification of each of the 32 source registers, the pad encoding, alignment and label-matching rules applied to sweeps of PCs, labels and near-miss opcodes, the survival of the expectation across stalls, and the cause and trap values carried by each pulse.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int unsigned LBL_W     = 20;
  localparam int unsigned CAUSE_SWC = 18;
  localparam int unsigned TVAL_PAD  = 2;
  localparam logic [6:0]  OPC_AUIPC = 7'b0010111;

  // Pad form: AUIPC writing x0.
  function automatic logic pad_form(input logic [31:0] insn);
    return (insn[6:0] == OPC_AUIPC) && (insn[11:7] == 5'd0);
  endfunction

  function automatic logic [LBL_W-1:0] pad_label(input logic [31:0] insn);
    return insn[31:12];
  endfunction

  function automatic logic pad_aligned(input logic [1:0] pc_lo);
    return pc_lo == 2'b00;
  endfunction

  // Zero label matches anything; otherwise exact match with x7's label.
  function automatic logic label_match(input logic [LBL_W-1:0] lbl,
                                       input logic [LBL_W-1:0] x7_lbl);
    return (lbl == '0) || (lbl == x7_lbl);
  endfunction

  // Return registers and the software-guarded register skip tracking.
  function automatic logic src_exempt(input logic [4:0] src);
    return (src == 5'd1) || (src == 5'd5) || (src == 5'd7);
  endfunction
endpackage

// File: rtl/lpg_cfg.sv
module lpg_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_wdata_en,
  input  logic cfg_wdata_lock,
  output logic enable_q,
  output logic lock_q
);
  logic en_write_ok;
  assign en_write_ok = cfg_we && !lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      if (en_write_ok) enable_q <= cfg_wdata_en;
      if (cfg_we && cfg_wdata_lock) lock_q <= 1'b1;
    end
  end

  assert_enable_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (enable_q == $past(enable_q)));
  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_enable_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !lock_q) |=> (enable_q == $past(cfg_wdata_en)));
endmodule

// File: rtl/lpg_decode.sv
module lpg_decode
  import lpg_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:0]     insn,
  input  logic [1:0]      pc_lo,
  input  logic [XLEN-1:0] x7,
  input  logic            is_ijmp,
  input  logic [4:0]      src_reg,
  input  logic            enable,
  output logic            pad_ok,
  output logic            jump_tracked
);
  logic form_ok, align_ok, lbl_ok;
  logic [LBL_W-1:0] x7_lbl;

  assign x7_lbl       = x7[31:12];
  assign form_ok      = pad_form(insn);
  assign align_ok     = pad_aligned(pc_lo);
  assign lbl_ok       = label_match(pad_label(insn), x7_lbl);
  assign pad_ok       = form_ok && align_ok && lbl_ok;
  assign jump_tracked = enable && is_ijmp && !src_exempt(src_reg);

  always_comb begin
    assert_exempt_untracked_R2: assert (!(jump_tracked &&
      (src_reg == 5'd1 || src_reg == 5'd5 || src_reg == 5'd7)));
  end
endmodule

// File: rtl/lpg_track.sv
module lpg_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_valid,
  input  logic trap_taken,
  input  logic jump_tracked,
  input  logic pad_ok,
  output logic expect_q,
  output logic violation
);
  logic checking, arm;

  assign checking  = ret_valid && expect_q && !trap_taken;
  assign violation = checking && !pad_ok;
  assign arm       = ret_valid && !trap_taken && jump_tracked && !violation;

  always_ff @(posedge clk) begin
    if (!rst_n)          expect_q <= 1'b0;
    else if (trap_taken) expect_q <= 1'b0;
    else if (ret_valid)  expect_q <= arm;
  end

  assert_arm_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expect_q) |-> $past(jump_tracked && ret_valid));
  assert_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !jump_tracked) |=> !expect_q);
  assert_trap_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> !expect_q);
  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_valid && !trap_taken) |=> (expect_q == $past(expect_q)));
endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
  import lpg_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_valid,
  input  logic [XLEN-1:0] ret_pc,
  input  logic [31:0]     ret_insn,
  input  logic            ret_is_ijmp,
  input  logic [4:0]      ret_src_reg,
  input  logic [XLEN-1:0] ret_x7,
  input  logic            trap_taken,
  input  logic            cfg_we,
  input  logic            cfg_wdata_en,
  input  logic            cfg_wdata_lock,
  output logic            cfg_enable,
  output logic            cfg_locked,
  output logic            xcpt_valid,
  output logic [XLEN-1:0] xcpt_cause,
  output logic [XLEN-1:0] xcpt_tval
);
  logic pad_ok, jump_tracked, expect_q, violation;
  logic unused_bits;
  assign unused_bits = ^{ret_pc, ret_x7};

  lpg_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_wdata_en(cfg_wdata_en), .cfg_wdata_lock(cfg_wdata_lock),
    .enable_q(cfg_enable), .lock_q(cfg_locked)
  );

  lpg_decode #(.XLEN(XLEN)) u_dec (
    .insn(ret_insn), .pc_lo(ret_pc[1:0]), .x7(ret_x7),
    .is_ijmp(ret_is_ijmp), .src_reg(ret_src_reg), .enable(cfg_enable),
    .pad_ok(pad_ok), .jump_tracked(jump_tracked)
  );

  lpg_track u_trk (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .trap_taken(trap_taken),
    .jump_tracked(jump_tracked), .pad_ok(pad_ok),
    .expect_q(expect_q), .violation(violation)
  );

  assign xcpt_valid = violation;
  assign xcpt_cause = violation ? XLEN'(CAUSE_SWC) : '0;
  assign xcpt_tval  = violation ? XLEN'(TVAL_PAD)  : '0;

  assert_xcpt_needs_expect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xcpt_valid |-> (expect_q && ret_valid && !trap_taken));
  assert_no_expect_no_xcpt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !expect_q |-> !xcpt_valid);
  assert_disabled_no_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !cfg_enable) |=> !expect_q);
endmodule

// File: tb/test_lpad_guard.sv
module test_lpad_guard;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ret_valid = 0, ret_is_ijmp = 0, trap_taken = 0;
  logic [XLEN-1:0] ret_pc = '0, ret_x7 = '0;
  logic [31:0] ret_insn = '0;
  logic [4:0] ret_src_reg = '0;
  logic cfg_we = 0, cfg_wdata_en = 0, cfg_wdata_lock = 0;
  logic cfg_enable, cfg_locked, xcpt_valid;
  logic [XLEN-1:0] xcpt_cause, xcpt_tval;

  int total = 0, bad = 0;
  bit done = 0;
  bit m_exp = 0, m_en = 0, m_lock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpad_guard #(.XLEN(XLEN)) i_lpad_guard (.*);

  function automatic logic [31:0] mk_pad(input logic [19:0] lbl);
    return {lbl, 5'd0, 7'h17};
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle of retire-side stimulus, checked against a bench-side model.
  task automatic step(input bit v, input logic [31:0] pc, input logic [31:0] insn,
                      input bit ij, input logic [4:0] src, input logic [31:0] x7,
                      input bit trap, input string req);
    bit is_pad, ok, exp_x, tracked;
    @(negedge clk);
    ret_valid = v; ret_pc = pc; ret_insn = insn; ret_is_ijmp = ij;
    ret_src_reg = src; ret_x7 = x7; trap_taken = trap;
    is_pad  = (insn[6:0] == 7'h17) && (insn[11:7] == 0);
    ok      = is_pad && (pc % 4 == 0) && (insn[31:12] == 0 || insn[31:12] == x7[31:12]);
    exp_x   = v && !trap && m_exp && !ok;
    tracked = m_en && ij && !(src == 1 || src == 5 || src == 7);
    #1;
    check(xcpt_valid == exp_x, req, xcpt_valid, exp_x);
    if (exp_x)
      check(xcpt_cause == 18 && xcpt_tval == 2, "R7", xcpt_cause*100 + xcpt_tval, 1802);
    @(posedge clk);
    if (trap) m_exp = 0;
    else if (v) m_exp = tracked && !exp_x;
    #1;
    ret_valid = 0; trap_taken = 0;
  endtask

  task automatic cfg(input bit en, input bit lk);
    @(negedge clk);
    cfg_we = 1; cfg_wdata_en = en; cfg_wdata_lock = lk;
    @(posedge clk);
    if (!m_lock) m_en = en;
    if (lk) m_lock = 1;
    @(negedge clk);
    cfg_we = 0;
    check(cfg_enable == m_en, "R10", cfg_enable, m_en);
    check(cfg_locked == m_lock, "R11", cfg_locked, m_lock);
  endtask

  task automatic jump(input logic [4:0] src, input string req);
    step(1, 32'h100, 32'h000300e7, 1, src, 32'h0, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check(!cfg_enable && !cfg_locked && !xcpt_valid, "R12", cfg_enable+cfg_locked, 0);

    // R3: disabled, no source arms
    for (int s = 0; s < 32; s++) begin
      jump(5'(s), "R3");
      step(1, 32'h200, 32'h13, 0, 0, 0, 0, "R3");
    end

    cfg(1, 0);
    // R1 R2 R4: source register sweep followed by a non-pad
    for (int s = 0; s < 32; s++) begin
      jump(5'(s), "R1");
      step(1, 32'h200, 32'h13, 0, 0, 0, 0, (s == 1 || s == 5 || s == 7) ? "R2" : "R1");
    end

    // R5 R6: alignment and label sweep
    for (int a = 0; a < 4; a++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          logic [19:0] l1, l2;
          l1 = (i == 0) ? 20'h0 : (i == 1) ? 20'h1 : (i == 2) ? 20'h5a5a5 : 20'hfffff;
          l2 = (j == 0) ? 20'h0 : (j == 1) ? 20'h1 : (j == 2) ? 20'h5a5a5 : 20'hfffff;
          jump(5'd6, "R6");
          step(1, 32'h400 + 32'(a), mk_pad(l1), 0, 0, {l2, 12'habc}, 0, (a != 0) ? "R5" : "R6");
        end

    // R4: near-miss encodings
    for (int rd = 1; rd < 32; rd += 5) begin
      jump(5'd10, "R4");
      step(1, 32'h500, {20'h0, 5'(rd), 7'h17}, 0, 0, 0, 0, "R4");
    end
    for (int b = 0; b < 7; b++) begin
      jump(5'd11, "R4");
      step(1, 32'h500, mk_pad(20'h0) ^ (32'd1 << b), 0, 0, 0, 0, "R4");
    end
    jump(5'd12, "R4");
    step(1, 32'h500, mk_pad(20'h0), 0, 0, 0, 0, "R4");

    // R9: pad with no expectation
    step(1, 32'h602, mk_pad(20'h123), 0, 0, 32'h0, 0, "R9");
    step(1, 32'h600, mk_pad(20'h123), 0, 0, 32'h0, 0, "R9");

    // R8: stall keeps expectation, trap clears it
    jump(5'd13, "R8");
    for (int k = 0; k < 3; k++) step(0, 0, 32'h13, 0, 0, 0, 0, "R8");
    step(1, 32'h700, 32'h13, 0, 0, 0, 0, "R8");
    jump(5'd13, "R8");
    step(0, 0, 32'h13, 0, 0, 0, 1, "R8");
    step(1, 32'h700, 32'h13, 0, 0, 0, 0, "R8");
    jump(5'd13, "R8");
    step(1, 32'h700, 32'h13, 0, 0, 0, 1, "R8");
    step(1, 32'h700, 32'h13, 0, 0, 0, 0, "R8");
    // R7: pulse lasts one retire only; violating jump does not re-arm (R1)
    jump(5'd14, "R7");
    step(1, 32'h800, 32'h000300e7, 1, 5'd14, 0, 0, "R1");
    step(1, 32'h804, 32'h13, 0, 0, 0, 0, "R7");

    // R10 R11: enable toggle and lock
    cfg(0, 0);
    jump(5'd6, "R10");
    step(1, 32'h900, 32'h13, 0, 0, 0, 0, "R10");
    cfg(1, 1);
    cfg(0, 0);
    jump(5'd6, "R11");
    step(1, 32'h900, 32'h13, 0, 0, 0, 0, "R11");
    cfg(0, 1);

    // R11 R12: reset clears lock
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_en = 0; m_lock = 0; m_exp = 0;
    #1;
    check(!cfg_locked && !cfg_enable, "R11", cfg_locked, 0);
    jump(5'd6, "R12");
    step(1, 32'h900, 32'h13, 0, 0, 0, 0, "R12");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule